// File: doc/BRIEF.md
# Bit-Addressed Serial Configuration Receiver

This block is the target side of a three-wire configuration port: an active-low select, a serial clock and a serial data line. Each wire passes through its own synchronizer into the system clock domain. An edge detector finds the high-to-low transitions of the serial clock, and the block takes one data bit at each of them. Eight bits make one command. A command sets or clears exactly one of 64 configuration latches, so the host changes a single bit per byte rather than a whole register.

The first bit of a command is the value to store. The next six bits are the latch address, most significant bit first. The eighth bit is a pad bit, and its value is discarded. Any number of commands may follow one another while select stays low. When select is released before a command is complete, the partial command is thrown away. All 64 latch values are driven out in parallel. A one-cycle strobe marks each cycle in which a command was applied.

Top module: `cfg_serial_rx`

## Requirements
- R1: While `rstN` is low, `cfgBits` is all zero and `wrStrobe` is low.
- R2: A command is eight bits. Each bit is sampled on a falling edge of `sclIn` while `selN` is low. Bit 1 is the value, bits 2 to 7 are the address (MSB first), and bit 8 is a pad. After the eighth bit, `cfgBits[address]` takes the value.
- R3: The pad bit has no effect, so 0xE8 and 0xE9 both set `cfgBits[52]` to 1.
- R4: A command whose value bit is 0 clears the addressed latch.
- R5: An applied command changes no latch other than the addressed one, and `cfgBits` changes only in a cycle where `wrStrobe` is high.
- R6: While `selN` is high, activity on `sclIn` and `sdaIn` changes no latch and raises no strobe.
- R7: If `selN` rises before eight bits have been sampled, those bits are discarded. The next select-low window starts a fresh command.
- R8: Several commands sent back to back in one select-low window are each applied in order.
- R9: `wrStrobe` is high for exactly one system clock for each applied command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low port select; idle high |
| sclIn | input | 1 | Serial clock; idle high, sampled on its falling edge |
| sdaIn | input | 1 | Serial data; idle high |
| cfgBits | output | 64 | Parallel configuration latch values |
| wrStrobe | output | 1 | One-cycle pulse for each applied command |

## Verification
Two situations are hard to reach from the ports: a select window that closes part-way through a command, and clock activity on the port while it is not selected. In both cases the latches must stay exactly as they were, and the next command must still be framed correctly. The random stimulus picks an abort position from one to seven bits into a command and sometimes toggles the clock and data lines while select is high. A bench model tracks which commands complete, and both the latch vector and the strobe count are compared with it after every window.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;    // take one serial bit
    logic commit;     // eighth bit: apply the assembled command
    logic clearShift; // port deselected: drop partial bits
  } ctlStrobe_t;
endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '1;
    else       pipe[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '1;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cfg_rx_ctrl.sv
module cfg_rx_ctrl
  import cfg_rx_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selS,
  input  logic       sclS,
  output ctlStrobe_t ctl
);
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

  logic             sclPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             fallEdge;
  logic             active;

  assign fallEdge = sclPrev & ~sclS;
  assign active   = ~selS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitCnt <= '0;
    else if (!active)        bitCnt <= '0;
    else if (fallEdge)       bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    ctl.shiftEn    = active & fallEdge;
    ctl.commit     = active & fallEdge & (bitCnt == LAST);
    ctl.clearShift = ~active;
  end
endmodule

// File: rtl/cfg_rx_datapath.sv
module cfg_rx_datapath
  import cfg_rx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdaS,
  input  ctlStrobe_t               ctl,
  output logic [(1<<ADDR_W)-1:0]   cfgBits,
  output logic                     wrStrobe
);
  localparam int NUM_BITS = 1 << ADDR_W;
  localparam int HOLD_W   = ADDR_W + 1; // value bit plus address

  logic [HOLD_W-1:0] holdReg;
  logic [ADDR_W-1:0] tgtAddr;
  logic              tgtVal;

  assign tgtAddr = holdReg[ADDR_W-1:0];
  assign tgtVal  = holdReg[ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdReg <= '0;
    else if (ctl.clearShift) holdReg <= '0;
    else if (ctl.shiftEn)    holdReg <= {holdReg[HOLD_W-2:0], sdaS};
  end

  for (genvar i = 0; i < NUM_BITS; i++) begin : gLatch
    logic hit;
    assign hit = ctl.commit & (tgtAddr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    cfgBits[i] <= 1'b0;
      else if (hit) cfgBits[i] <= tgtVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrStrobe <= 1'b0;
    else       wrStrobe <= ctl.commit;
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int CMD_W       = ADDR_W + 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   selN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic [(1<<ADDR_W)-1:0] cfgBits,
  output logic                   wrStrobe
);
  logic [2:0] pinSync;
  ctlStrobe_t ctl;

  cfg_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({selN, sclIn, sdaIn}),
    .dout (pinSync)
  );

  cfg_rx_ctrl #(.CMD_W(CMD_W)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .selS (pinSync[2]),
    .sclS (pinSync[1]),
    .ctl  (ctl)
  );

  cfg_rx_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .sdaS     (pinSync[0]),
    .ctl      (ctl),
    .cfgBits  (cfgBits),
    .wrStrobe (wrStrobe)
  );
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int NUM_BITS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                selN,
  input logic [NUM_BITS-1:0] cfgBits,
  input logic                wrStrobe
);
  logic [3:0] selHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        selHighCnt <= '0;
    else if (!selN)   selHighCnt <= '0;
    else if (selHighCnt != 4'hF) selHighCnt <= selHighCnt + 1'b1;
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (cfgBits == '0 && !wrStrobe);
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  a_r5_change_only_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> $stable(cfgBits));

  a_r5_one_bit_per_write: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cfgBits ^ $past(cfgBits)) <= 1);

  a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (selHighCnt >= 4'd4) |-> !wrStrobe);
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.NUM_BITS(1 << ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .selN     (selN),
  .cfgBits  (cfgBits),
  .wrStrobe (wrStrobe)
);

// File: tb/sim_cfg_serial_rx.sv
module sim_cfg_serial_rx;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selN = 1'b1;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b1;
  logic [63:0] cfgBits;
  logic        wrStrobe;

  int          nTests = 0;
  int          nFail  = 0;
  int          strobeCnt = 0;
  bit          done = 1'b0;
  logic [63:0] model = '0;
  int          expStrobes = 0;

  always #10 clk = ~clk; // 50 MHz

  cfg_serial_rx u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cfgBits(cfgBits), .wrStrobe(wrStrobe)
  );

  always @(negedge clk) if (wrStrobe) strobeCnt++;

  function automatic logic [7:0] mkCmd(bit val, logic [5:0] addr, bit pad);
    return {val, addr, pad};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b);
    sdaIn = b;
    waitClk(HALF);
    sclIn = 1'b0;
    waitClk(HALF);
    sclIn = 1'b1;
  endtask

  task automatic openWin();
    selN = 1'b0;
    waitClk(4);
  endtask

  task automatic closeWin();
    waitClk(4);
    selN = 1'b1;
    sdaIn = 1'b1;
    waitClk(6);
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    model[b[6:1]] = b[7];
    expStrobes++;
  endtask

  task automatic sendPartial(logic [7:0] b, int nBits);
    for (int i = 7; i > 7 - nBits; i--) sendBit(b[i]);
  endtask

  task automatic checkState(string req);
    check(cfgBits == model, req, cfgBits, model);
    check(strobeCnt == expStrobes, req, 64'(strobeCnt), 64'(expStrobes));
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    waitClk(3);
    check(cfgBits == '0 && !wrStrobe, "R1", cfgBits, '0);
    rstN = 1'b1;
    waitClk(4);

    // R2 R3: 0xE8 sets bit 52
    openWin(); sendByte(8'hE8); closeWin();
    check(cfgBits[52] == 1'b1, "R3", 64'(cfgBits[52]), 64'd1);
    checkState("R2");
    // R4: clear bit 52
    openWin(); sendByte(mkCmd(1'b0, 6'd52, 1'b0)); closeWin();
    checkState("R4");
    // R3: 0xE9 also sets bit 52
    openWin(); sendByte(8'hE9); closeWin();
    check(cfgBits[52] == 1'b1, "R3", 64'(cfgBits[52]), 64'd1);
    // R8: several bytes one window, boundary addresses
    openWin();
    sendByte(mkCmd(1'b1, 6'd0, 1'b1));
    sendByte(mkCmd(1'b1, 6'd63, 1'b0));
    sendByte(mkCmd(1'b0, 6'd0, 1'b1));
    closeWin();
    checkState("R8");
    // R6: activity while deselected
    for (int i = 0; i < 16; i++) sendBit(i[0]);
    waitClk(6);
    checkState("R6");
    // R7: partial byte then fresh byte
    openWin(); sendPartial(mkCmd(1'b1, 6'd5, 1'b0), 5); closeWin();
    checkState("R7");
    openWin(); sendByte(mkCmd(1'b1, 6'd9, 1'b0)); closeWin();
    check(cfgBits[5] == 1'b0 && cfgBits[9] == 1'b1, "R7", cfgBits, model);
    checkState("R9");

    // Random windows
    for (int w = 0; w < 60; w++) begin
      int nb = 1 + ($urandom % 4);
      openWin();
      for (int k = 0; k < nb; k++) sendByte(8'($urandom));
      if (($urandom % 3) == 0) sendPartial(8'($urandom), 1 + ($urandom % 7));
      closeWin();
      if (($urandom % 4) == 0) begin
        for (int i = 0; i < 8; i++) sendBit(1'($urandom));
        waitClk(6);
      end
      checkState("R5");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule